// File: doc/BRIEF.md
# Synchronous Serial Host Port

This block is the device side of a clocked serial link through which a host processor loads instructions and display-memory bytes into a display controller, or reads display-memory bytes back. The host lowers an active-low select, toggles a serial clock and moves one data line. The port brings the select, clock and data into the system clock domain through synchronizers. The system clock must run at least four times as fast as the serial clock.

Every transfer opens with a header byte. The high five bits of the header are a fixed device code, `01110`. The next bit must equal the level on the `dev_id` pin. The two low bits pick the target and the direction. A header that fails either test makes the port ignore the rest of the transfer. After a write header, each complete byte appears once on a one-cycle strobe, tagged instruction or data. After a read header, the port drives the line: it first sends a fixed number of filler bytes, then one memory byte per slot, and each slot it fills from memory raises a fetch strobe towards the memory.

Top module: `sshp_port`

## Requirements
- R1: After reset, `sdo_oe`, `wr_valid` and `rd_req` are low.
- R2: The first byte after `cs_n` falls is the header, sent MSB first. It is accepted only if bits 7:3 are `01110` and bit 2 equals `dev_id`. Otherwise no write strobe and no read drive occur until `cs_n` rises.
- R3: Header bit 1 selects the target. 0 gives `wr_rs`=0 (instruction) and 1 gives `wr_rs`=1 (memory data).
- R4: With header bit 0 = 0 (write), each following complete byte is sampled MSB first on rising `sclk` edges. It produces exactly one `wr_valid` pulse with that byte on `wr_byte`.
- R5: A write transfer keeps accepting bytes until `cs_n` rises. No new header is needed between bytes.
- R6: If `cs_n` rises before a byte is complete, the partial byte is discarded. The next transfer begins again with a header.
- R7: While `cs_n` is high, edges on `sclk` and values on `sdi` have no effect.
- R8: With header bit 0 = 1 (read), `sdo_oe` goes high and incoming bytes are never written. The first two bytes returned are 0x00. Every later byte slot takes `rd_data`, with one `rd_req` pulse per slot. Bits go out MSB first and change after falling `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_id | input | 1 | Device identity level that header bit 2 must match |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| wr_valid | output | 1 | One-cycle strobe for a received byte |
| wr_rs | output | 1 | Target of the strobed byte: 0 instruction, 1 data |
| wr_byte | output | 8 | Received byte |
| rd_req | output | 1 | Fetch strobe; `rd_data` is taken in the same cycle |
| rd_data | input | 8 | Memory byte offered to the port |

## Verification
A rising `sclk` edge passes through two synchronizer stages and one edge register, so the eighth bit of a byte yields `wr_valid` about four system clocks after that edge. The bench waits six clocks on each `sclk` phase and records strobes as they occur, then compares the counts and last values after the transfer closes. Read bits change about four clocks after a falling edge. The bench therefore samples `sdo` six clocks after each fall, just before it raises `sclk`. `rd_req` counts are compared once the select has returned high.

// File: rtl/sshp_pkg.sv
package sshp_pkg;
  typedef enum logic [1:0] {PH_HEAD, PH_WRITE, PH_READ, PH_SKIP} phase_t;

  localparam logic [4:0] DEV_CODE = 5'b01110;

  // header acceptance: fixed code in [7:3], identity in [2]
  function automatic logic head_hit(input logic [7:0] b, input logic id);
    return (b[7:3] == DEV_CODE) && (b[2] == id);
  endfunction
endpackage

// File: rtl/sshp_sync.sv
module sshp_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[g] <= RST_VAL;
      else if (g == 0) pipe[g] <= d;
      else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sshp_rx.sv
module sshp_rx
  import sshp_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          rise,
  input  logic          sdi_s,
  input  logic          dev_id,
  output phase_t        phase,
  output logic          byte_done,
  output logic          head_ok,
  output logic          wr_valid,
  output logic          wr_rs,
  output logic [BW-1:0] wr_byte
);
  localparam int CW = $clog2(BW);

  logic [CW-1:0] bit_q;
  logic [BW-1:0] sh_q;
  logic          rs_q;
  logic [BW-1:0] nxt;

  assign nxt       = {sh_q[BW-2:0], sdi_s};
  assign byte_done = cs_act && rise && (bit_q == CW'(BW-1));
  assign head_ok   = byte_done && (phase == PH_HEAD) && head_hit(nxt, dev_id);

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      bit_q    <= '0;
      sh_q     <= '0;
      phase    <= PH_HEAD;
      rs_q     <= 1'b0;
      wr_valid <= 1'b0;
      if (!rst_n) begin
        wr_rs   <= 1'b0;
        wr_byte <= '0;
      end
    end else begin
      wr_valid <= 1'b0;
      if (rise) begin
        sh_q  <= nxt;
        bit_q <= bit_q + 1'b1;
      end
      if (byte_done) begin
        case (phase)
          PH_HEAD: begin
            if (head_hit(nxt, dev_id)) begin
              phase <= nxt[0] ? PH_READ : PH_WRITE;
              rs_q  <= nxt[1];
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_WRITE: begin
            wr_valid <= 1'b1;
            wr_byte  <= nxt;
            wr_rs    <= rs_q;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sshp_tx.sv
module sshp_tx #(
  parameter int BW = 8,
  parameter int DUMMY = 2,
  parameter logic [BW-1:0] FILL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reading,
  input  logic          fall,
  input  logic [BW-1:0] rd_data,
  output logic          sdo,
  output logic          rd_req,
  output logic          load
);
  localparam int CW = $clog2(BW);
  localparam int IW = $clog2(DUMMY + 1);

  logic [CW-1:0] obit;
  logic [IW-1:0] idx;
  logic [BW-1:0] osh;
  logic          past_dummy;

  assign past_dummy = (idx == IW'(DUMMY));
  assign load       = reading && fall && (obit == '0);
  assign rd_req     = load && past_dummy;
  assign sdo        = osh[BW-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !reading) begin
      obit <= '0;
      idx  <= '0;
      osh  <= '0;
    end else if (fall) begin
      obit <= obit + 1'b1;
      if (obit == '0) begin
        osh <= past_dummy ? rd_data : FILL;
        if (!past_dummy) idx <= idx + 1'b1;
      end else begin
        osh <= {osh[BW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sshp_port.sv
module sshp_port
  import sshp_pkg::*;
#(
  parameter int BW = 8,
  parameter int DUMMY = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_id,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          wr_valid,
  output logic          wr_rs,
  output logic [BW-1:0] wr_byte,
  output logic          rd_req,
  input  logic [BW-1:0] rd_data
);
  logic [2:0] raw, syn;
  logic       sclk_d;
  logic       cs_act, rise, fall, reading;
  logic       byte_done, head_ok, load;
  phase_t     phase;

  assign raw = {cs_n, sclk, sdi};

  sshp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_d <= 1'b0;
    else sclk_d <= syn[1];
  end

  assign cs_act  = !syn[2];
  assign rise    = syn[1] && !sclk_d;
  assign fall    = !syn[1] && sclk_d;
  assign reading = cs_act && (phase == PH_READ);
  assign sdo_oe  = reading;

  sshp_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .sdi_s(syn[0]),
    .dev_id(dev_id), .phase(phase), .byte_done(byte_done), .head_ok(head_ok),
    .wr_valid(wr_valid), .wr_rs(wr_rs), .wr_byte(wr_byte)
  );

  sshp_tx #(.BW(BW), .DUMMY(DUMMY)) u_tx (
    .clk(clk), .rst_n(rst_n), .reading(reading), .fall(fall),
    .rd_data(rd_data), .sdo(sdo), .rd_req(rd_req), .load(load)
  );
endmodule

module sshp_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic head_ok,
  input logic byte_done,
  input logic load,
  input logic sdo_oe,
  input logic wr_valid,
  input logic rd_req
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !sdo_oe && !wr_valid);
  // R2
  drive_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(head_ok));
  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R4
  strobe_from_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(byte_done));
  // R7
  idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !byte_done && !load);
  // R8
  fetch_when_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> sdo_oe && load);
  // R8
  no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sdo_oe);
endmodule

bind sshp_port sshp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .head_ok(head_ok),
  .byte_done(byte_done), .load(load), .sdo_oe(sdo_oe),
  .wr_valid(wr_valid), .rd_req(rd_req)
);

// File: tb/sim_sshp_port.sv
`timescale 1ns/1ps
module sim_sshp_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_id = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, wr_valid, wr_rs, rd_req;
  logic [7:0] wr_byte, rd_data;

  int vectors = 0;
  int fails = 0;
  int wcount = 0;
  int rcount = 0;
  logic [7:0] last_b = '0;
  logic last_rs = 1'b0;
  logic [7:0] ptr = '0;

  always #10 clk = ~clk;

  sshp_port u0 (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .cs_n(cs_n), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .wr_valid(wr_valid), .wr_rs(wr_rs),
    .wr_byte(wr_byte), .rd_req(rd_req), .rd_data(rd_data)
  );

  // memory stub: byte k of the stream is k*7 + 0x31
  assign rd_data = ptr * 8'd7 + 8'h31;
  always @(posedge clk) if (!rst_n) ptr <= '0; else if (rd_req) ptr <= ptr + 8'd1;

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      wcount++;
      last_b = wr_byte;
      last_rs = wr_rs;
    end
    if (rst_n && rd_req) rcount++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      wclk(6);
      sdi = b[i];
      got[i] = sdo;
      sclk = 1'b1;
      wclk(6);
    end
  endtask

  task automatic open_x();
    cs_n = 1'b0;
    wclk(6);
  endtask

  task automatic close_x();
    wclk(6);
    cs_n = 1'b1;
    sclk = 1'b0;
    wclk(8);
  endtask

  function automatic bit hit(input logic [7:0] s, input logic id);
    return (s[7:3] == 5'b01110) && (s[2] == id);
  endfunction

  initial begin
    wclk(150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] g0, g1, g2, g3, g4;
    int w0, r0;
    logic [7:0] p;
    wclk(4);
    rst_n = 1'b1;
    wclk(2);
    // R1 reset state
    check(!sdo_oe && !wr_valid && !rd_req, "R1", {sdo_oe, wr_valid, rd_req}, 0);

    // R2 R3 R4 R5 R8: header sweep, both identity levels
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] sb;
        bit acc;
        sb = 8'(s);
        if (d == 1 && sb[7:5] != 3'b011) continue;
        dev_id = d[0];
        acc = hit(sb, dev_id);
        w0 = wcount;
        r0 = rcount;
        open_x();
        xbyte(sb, g0);
        xbyte(sb ^ 8'h5A, g1);
        xbyte(~sb, g2);
        close_x();
        if (acc && !sb[0]) begin
          check(wcount - w0 == 2, "R4 R5 byte count", wcount - w0, 2);
          check(last_b == ~sb, "R4 last byte", last_b, ~sb);
          check(last_rs == sb[1], "R3 target", last_rs, sb[1]);
        end else if (acc) begin
          check(wcount == w0, "R8 no write in read", wcount - w0, 0);
          check(g1 == 8'h00 && g2 == 8'h00, "R8 filler bytes", {g1, g2}, 0);
          check(rcount == r0, "R8 no fetch in filler", rcount - r0, 0);
        end else begin
          check(wcount == w0, "R2 rejected header", wcount - w0, 0);
        end
      end
    end

    // R8 long read with memory bytes
    dev_id = 1'b1;
    p = ptr;
    r0 = rcount;
    open_x();
    xbyte(8'h77, g0);
    wclk(1);
    check(sdo_oe, "R8 drive enable", sdo_oe, 1);
    xbyte(8'hFF, g0);
    xbyte(8'hFF, g1);
    xbyte(8'hFF, g2);
    xbyte(8'hFF, g3);
    xbyte(8'hFF, g4);
    close_x();
    check(g0 == 0 && g1 == 0, "R8 first two bytes", {g0, g1}, 0);
    check(g2 == 8'(p * 7 + 8'h31), "R8 byte 3", g2, 8'(p * 7 + 8'h31));
    check(g3 == 8'((p + 1) * 7 + 8'h31), "R8 byte 4", g3, 8'((p + 1) * 7 + 8'h31));
    check(g4 == 8'((p + 2) * 7 + 8'h31), "R8 byte 5", g4, 8'((p + 2) * 7 + 8'h31));
    check(rcount - r0 == 3, "R8 fetch count", rcount - r0, 3);
    check(!sdo_oe, "R8 release", sdo_oe, 0);

    // R6 partial byte dropped, next transfer needs a header
    dev_id = 1'b0;
    w0 = wcount;
    open_x();
    xbyte(8'h70, g0);
    xbyte(8'h11, g0);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; wclk(6); sdi = 1'b1; sclk = 1'b1; wclk(6);
    end
    close_x();
    check(wcount - w0 == 1 && last_b == 8'h11, "R6 partial discarded", wcount - w0, 1);
    open_x();
    xbyte(8'h72, g0);
    xbyte(8'h22, g0);
    close_x();
    check(wcount - w0 == 2 && last_b == 8'h22 && last_rs, "R6 fresh header", last_b, 8'h22);

    // R7 clock activity while deselected
    w0 = wcount;
    for (int i = 0; i < 5; i++) begin
      sdi = i[0]; sclk = 1'b1; wclk(6); sclk = 1'b0; wclk(6);
    end
    check(wcount == w0, "R7 idle no strobe", wcount - w0, 0);
    open_x();
    xbyte(8'h70, g0);
    xbyte(8'h33, g0);
    close_x();
    check(wcount - w0 == 1 && last_b == 8'h33 && !last_rs, "R7 count untouched", last_b, 8'h33);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule